// File: doc/BRIEF.md
# Prioritized Interrupt Request Recognizer

This block stands between seven active-low interrupt request lines and a processor core's exception sequencer. Each line is sampled on every clock edge and has to stay asserted for a set number of consecutive samples before it counts as valid. A valid request becomes a candidate only when its level is above the current 3-bit priority mask. The highest candidate is recomputed every cycle from the live inputs and is never latched. Candidates are only pending. The block takes one when the core signals an instruction boundary or the end of a higher-priority exception.

Level 7 cannot be masked, but it reacts to edges. It fires once for each fresh assertion of its line. It fires again when the mask is lowered from 7 while the line is still held. When a request is taken, the block pulses `ack_start` and drives the serviced level on `ack_level` and inside `ack_addr`. It also writes that level into the mask. It then takes nothing else until `ack_done` arrives. The mask can also be written from outside with `mask_load`.

Top module: `irq_recognizer`

## Requirements
- R1: After a synchronous active-high reset, `mask_out` is 3'b111, `ack_start` is 0, `ack_level` is 0 and no request is pending.
- R2: A line counts as valid only after it is sampled low on FILTER_DEPTH (default 2) consecutive rising edges. A line that is low for a single sample is never serviced.
- R3: A valid request above the mask causes no `ack_start` while `inst_boundary` and `exc_done` are both low. It is taken on the first edge where either one is high.
- R4: A request on levels 1 to 6 whose level is less than or equal to `mask_out` is ignored.
- R5: When several valid requests are above the mask in the same cycle, the highest level is serviced.
- R6: The pending level is not latched. If a higher request becomes valid while a lower one waits for a boundary, the higher one is serviced.
- R7: Level 7 (line bit 6) is serviced whatever the mask value. A single held assertion is serviced only once.
- R8: Lowering the mask from 3'b111 to any smaller value through `mask_load` while line 7 is still valid creates a new level-7 service.
- R9: On acceptance, `mask_out` becomes the serviced level and `ack_level` shows it. `ack_addr` is all ones except bits [3:1], which carry the level, so bit 0 is 1.
- R10: `ack_start` is high for exactly one cycle per acceptance. `ack_level` holds steady and no further `ack_start` occurs until an `ack_done` cycle has been seen.
- R11: If line 7 is released before its service is taken, the level-7 event is dropped and not serviced later.
- R12: `mask_load` writes `mask_in` into the mask on any edge where no request is being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 7 | Active-low request lines; bit i is level i+1 |
| mask_load | input | 1 | Write `mask_in` into the priority mask |
| mask_in | input | 3 | New mask value |
| inst_boundary | input | 1 | Core is at an instruction boundary |
| exc_done | input | 1 | Higher-priority exception processing has finished |
| ack_done | input | 1 | Acknowledge cycle finished; frees the sequencer |
| ack_start | output | 1 | One-cycle pulse starting an acknowledge cycle |
| ack_level | output | 3 | Level being serviced, held until `ack_done` |
| ack_addr | output | ACK_ADDR_W | Acknowledge address carrying the level in bits [3:1] |
| mask_out | output | 3 | Current priority mask |

## Verification
The bench targets a single-sample glitch, which a filter with too few stages would service. It raises a higher level while a lower one waits for a boundary, which catches a latched level. It holds level 7 across many boundaries, where a level-only detector would fire again and again. It also lowers the mask under a held level 7, where a design that missed the mask-drop event would stay silent. Requests equal to the mask and requests raised while an acknowledge is outstanding check the mask compare and the hold-until-done rule. Random masks and line patterns are checked against a bench function that picks the highest level above the mask.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;

    localparam int LVL_W   = 3;
    localparam int NUM_LVL = 7;

    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [NUM_LVL-1:0] lines_t;

    localparam lvl_t LVL_TOP = 3'd7;

    typedef struct packed {
        logic hit;
        lvl_t lvl;
    } pick_t;

    // Highest set bit of a per-level candidate vector; bit i means level i+1.
    function automatic pick_t pick_highest(lines_t cand);
        pick_t p;
        p.hit = 1'b0;
        p.lvl = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (cand[i]) begin
                p.hit = 1'b1;
                p.lvl = lvl_t'(i + 1);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/irq_input_filter.sv
module irq_input_filter
    import irq_rec_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  lines_t irq_n,
    output lines_t valid
);
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_line
        logic [DEPTH-1:0] hist_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                hist_q <= '0;
            end else if (DEPTH == 1) begin
                hist_q <= DEPTH'(~irq_n[g]);
            end else begin
                hist_q <= {hist_q[DEPTH-2:0], ~irq_n[g]};
            end
        end
        assign valid[g] = &hist_q;
    end
endmodule

// File: rtl/irq_nmi_detect.sv
module irq_nmi_detect
    import irq_rec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic top_valid,
    input  lvl_t mask_q,
    input  logic mask_wr,
    input  lvl_t mask_wdata,
    input  logic taken,
    output logic nmi_req
);
    logic prev_q;
    logic pend_q;
    logic fresh;
    logic drop;

    assign fresh   = top_valid & ~prev_q;
    assign drop    = top_valid & mask_wr & (mask_q == LVL_TOP) & (mask_wdata != LVL_TOP);
    assign nmi_req = top_valid & (pend_q | fresh);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= top_valid;
            pend_q <= top_valid & (pend_q | fresh | drop) & ~taken;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_rec_pkg::*;
(
    input  lines_t valid,
    input  logic   nmi_req,
    input  lvl_t   mask_q,
    output pick_t  pick
);
    lines_t cand;

    always_comb begin
        cand = '0;
        for (int i = 0; i < NUM_LVL - 1; i++) begin
            cand[i] = valid[i] & (lvl_t'(i + 1) > mask_q);
        end
        cand[NUM_LVL-1] = nmi_req;
        pick = pick_highest(cand);
    end
endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
    import irq_rec_pkg::*;
#(
    parameter int FILTER_DEPTH = 2,
    parameter int ACK_ADDR_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [6:0]            irq_n,
    input  logic                  mask_load,
    input  logic [2:0]            mask_in,
    input  logic                  inst_boundary,
    input  logic                  exc_done,
    input  logic                  ack_done,
    output logic                  ack_start,
    output logic [2:0]            ack_level,
    output logic [ACK_ADDR_W-1:0] ack_addr,
    output logic [2:0]            mask_out
);
    localparam int PAD_W = ACK_ADDR_W - LVL_W - 1;

    lines_t valid;
    logic   nmi_req;
    pick_t  pick;
    logic   accept;
    logic   mask_wr;
    logic   take_top;

    lvl_t   mask_q;
    lvl_t   level_q;
    logic   start_q;
    logic   busy_q;

    irq_input_filter #(.DEPTH(FILTER_DEPTH)) u_filter (
        .clk   (clk),
        .rst   (rst),
        .irq_n (irq_n),
        .valid (valid)
    );

    irq_nmi_detect u_nmi (
        .clk        (clk),
        .rst        (rst),
        .top_valid  (valid[NUM_LVL-1]),
        .mask_q     (mask_q),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_in),
        .taken      (take_top),
        .nmi_req    (nmi_req)
    );

    irq_arbiter u_arb (
        .valid   (valid),
        .nmi_req (nmi_req),
        .mask_q  (mask_q),
        .pick    (pick)
    );

    assign accept   = pick.hit & (inst_boundary | exc_done) & ~busy_q;
    assign mask_wr  = mask_load & ~accept;
    assign take_top = accept & (pick.lvl == LVL_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= LVL_TOP;
            level_q <= '0;
            start_q <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            start_q <= accept;
            if (accept) begin
                mask_q  <= pick.lvl;
                level_q <= pick.lvl;
                busy_q  <= 1'b1;
            end else begin
                if (mask_wr) mask_q <= mask_in;
                if (ack_done) busy_q <= 1'b0;
            end
        end
    end

    assign ack_start = start_q;
    assign ack_level = level_q;
    assign mask_out  = mask_q;
    assign ack_addr  = {{PAD_W{1'b1}}, level_q, 1'b1};

endmodule

// File: rtl/irq_recognizer_checker.sv
module irq_recognizer_checker (
    input logic       clk,
    input logic       rst,
    input logic [6:0] irq_n,
    input logic       inst_boundary,
    input logic       exc_done,
    input logic       ack_done,
    input logic       ack_start,
    input logic [2:0] ack_level,
    input logic [3:0] ack_addr_lo,
    input logic [2:0] mask_out,
    input logic       busy_q
);
    assert_start_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        ack_start |=> !ack_start);

    assert_level_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !ack_start |-> $stable(ack_level));

    assert_no_start_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !ack_done) |=> !ack_start);

    assert_mask_loaded_R9: assert property (@(posedge clk) disable iff (rst)
        ack_start |-> (mask_out == ack_level));

    assert_addr_level_R9: assert property (@(posedge clk) disable iff (rst)
        ack_start |-> (ack_addr_lo == {ack_level, 1'b1}));

    assert_above_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (ack_start && ack_level != 3'd7) |-> (ack_level > $past(mask_out)));

    assert_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        ack_start |-> $past(inst_boundary || exc_done));

    assert_top_line_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_start && ack_level == 3'd7) |-> $past(!irq_n[6]));
endmodule

bind irq_recognizer irq_recognizer_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .irq_n         (irq_n),
    .inst_boundary (inst_boundary),
    .exc_done      (exc_done),
    .ack_done      (ack_done),
    .ack_start     (ack_start),
    .ack_level     (ack_level),
    .ack_addr_lo   (ack_addr[3:0]),
    .mask_out      (mask_out),
    .busy_q        (busy_q)
);

// File: tb/irq_recognizer_test.sv
module irq_recognizer_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [6:0]    irq_n = 7'h7f;
    logic          mask_load = 1'b0;
    logic [2:0]    mask_in = 3'd0;
    logic          inst_boundary = 1'b0;
    logic          exc_done = 1'b0;
    logic          ack_done = 1'b0;
    logic          ack_start;
    logic [2:0]    ack_level;
    logic [AW-1:0] ack_addr;
    logic [2:0]    mask_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    irq_recognizer #(.FILTER_DEPTH(2), .ACK_ADDR_W(AW)) uut (
        .clk (clk), .rst (rst), .irq_n (irq_n),
        .mask_load (mask_load), .mask_in (mask_in),
        .inst_boundary (inst_boundary), .exc_done (exc_done),
        .ack_done (ack_done), .ack_start (ack_start),
        .ack_level (ack_level), .ack_addr (ack_addr), .mask_out (mask_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // bit i of lines (active high here) is level i+1
    function automatic int expect_level(input logic [5:0] lines, input int mask);
        int best = 0;
        for (int i = 0; i < 6; i++)
            if (lines[i] && (i + 1) > mask) best = i + 1;
        return best;
    endfunction

    // wait up to n ticks for ack_start, return level or 0
    task automatic wait_ack(input int n, output int lvl);
        lvl = 0;
        for (int k = 0; k < n; k++) begin
            tick();
            if (ack_start) begin
                lvl = ack_level;
                break;
            end
        end
    endtask

    task automatic finish_ack();
        ack_done = 1'b1;
        tick();
        ack_done = 1'b0;
    endtask

    task automatic set_mask(input int m);
        mask_load = 1'b1;
        mask_in = 3'(m);
        tick();
        mask_load = 1'b0;
    endtask

    task automatic no_ack(input int n, input string req);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            tick();
            if (ack_start) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lvl;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check(mask_out == 3'd7, "R1 mask", mask_out, 7);
        check(ack_start == 1'b0, "R1 start", ack_start, 0);
        check(ack_level == 3'd0, "R1 level", ack_level, 0);

        // R12 mask write
        set_mask(0);
        check(mask_out == 3'd0, "R12 mask write", mask_out, 0);

        // R3 pending without boundary, then taken
        irq_n[2] = 1'b0;
        no_ack(5, "R3 held pending");
        inst_boundary = 1'b1;
        tick();
        check(ack_start == 1'b1, "R3 taken at boundary", ack_start, 1);
        check(ack_level == 3'd3, "R9 level", ack_level, 3);
        check(mask_out == 3'd3, "R9 mask loaded", mask_out, 3);
        check(ack_addr == {{(AW-4){1'b1}}, 3'd3, 1'b1}, "R9 addr", ack_addr, {{(AW-4){1'b1}}, 3'd3, 1'b1});
        tick();
        check(ack_start == 1'b0, "R10 one-cycle pulse", ack_start, 0);
        // R10 hold until done: higher request while busy
        irq_n[5] = 1'b0;
        no_ack(6, "R10 blocked while busy");
        check(ack_level == 3'd3, "R10 level held", ack_level, 3);
        irq_n[2] = 1'b1;
        finish_ack();
        wait_ack(4, lvl);
        check(lvl == 6, "R10 serviced after done", lvl, 6);
        irq_n = 7'h7f;
        finish_ack();
        tick(); tick();

        // R2 single-sample glitch
        set_mask(0);
        irq_n[4] = 1'b0;
        tick();
        irq_n[4] = 1'b1;
        no_ack(6, "R2 glitch ignored");
        // R2 exact timing: two samples then accepted next edge
        irq_n[1] = 1'b0;
        tick(); tick();
        check(ack_start == 1'b0, "R2 not before filter", ack_start, 0);
        tick();
        check(ack_start == 1'b1 && ack_level == 3'd2, "R2 accepted", ack_level, 2);
        irq_n = 7'h7f;
        finish_ack();
        tick(); tick();

        // R4 equal and below mask ignored
        set_mask(4);
        irq_n[3] = 1'b0;
        irq_n[1] = 1'b0;
        no_ack(6, "R4 at or below mask");
        check(mask_out == 3'd4, "R4 mask unchanged", mask_out, 4);
        irq_n[4] = 1'b0;
        wait_ack(5, lvl);
        check(lvl == 5, "R4 above mask", lvl, 5);
        irq_n = 7'h7f;
        finish_ack();
        tick(); tick();

        // R5 simultaneous
        set_mask(0);
        irq_n[1] = 1'b0; irq_n[5] = 1'b0; irq_n[3] = 1'b0;
        wait_ack(5, lvl);
        check(lvl == 6, "R5 highest wins", lvl, 6);
        irq_n = 7'h7f;
        finish_ack();
        tick(); tick();

        // R6 not latched
        set_mask(0);
        inst_boundary = 1'b0;
        irq_n[1] = 1'b0;
        repeat (4) tick();
        irq_n[4] = 1'b0;
        repeat (3) tick();
        exc_done = 1'b1;
        wait_ack(3, lvl);
        exc_done = 1'b0;
        check(lvl == 5, "R6 higher replaces pending", lvl, 5);
        irq_n = 7'h7f;
        finish_ack();
        tick(); tick();

        // R7 level 7 ignores mask 7, serviced once
        inst_boundary = 1'b1;
        set_mask(7);
        irq_n[6] = 1'b0;
        wait_ack(5, lvl);
        check(lvl == 7, "R7 top level serviced", lvl, 7);
        finish_ack();
        no_ack(10, "R7 held line once");
        // R8 mask drop while held
        set_mask(3);
        wait_ack(4, lvl);
        check(lvl == 7, "R8 mask drop refires", lvl, 7);
        irq_n[6] = 1'b1;
        finish_ack();
        tick(); tick(); tick();

        // R11 released before service
        inst_boundary = 1'b0;
        set_mask(7);
        irq_n[6] = 1'b0;
        repeat (4) tick();
        irq_n[6] = 1'b1;
        repeat (4) tick();
        inst_boundary = 1'b1;
        no_ack(6, "R11 dropped event");

        // random patterns for R4/R5
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'h1234);
            for (int it = 0; it < 60; it++) begin
                logic [5:0] lines;
                int m;
                int exp;
                lines = 6'($urandom);
                m = $urandom % 7;
                inst_boundary = 1'b0;
                set_mask(m);
                irq_n = {1'b1, ~lines};
                repeat (3) tick();
                inst_boundary = 1'b1;
                exp = expect_level(lines, m);
                wait_ack(3, lvl);
                check(lvl == exp, "R5 random highest above mask", lvl, exp);
                irq_n = 7'h7f;
                if (lvl != 0) finish_ack();
                repeat (3) tick();
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule